// File: doc/BRIEF.md
# Start-Vector Gated Bit Recovery

This block sits behind a receiver's data slicer. It takes the sliced one-bit stream, brings it into the local clock domain and oversamples it at sixteen times the chosen bit rate. Bit timing is re-aligned on every input transition. The block watches the recovered bits for a fixed 16-bit start word. Until that word arrives, the data output simply follows the synchronized slicer level and the recovered-clock output stays low.

Once the start word has been matched, the data output carries the retimed bits and a recovered-clock pulse marks each one. The bit is presented at the pulse's rising edge and is steady through its falling edge. The lock holds until the enable input is taken low. Taking it high again re-arms the search. A rate input selects one of two oversampling divisors, for a slow rate and a fast rate. Both divisors are build parameters. With a 100 MHz clock the defaults give about 4.8 kbps and 19.2 kbps.

The serial output has no valid/ready handshake and offers no back-pressure, because the output is a line level qualified by a clock. The consumer must take each bit on the falling edge of its pulse, before the next bit arrives one bit period later. The enable and rate inputs are plain synchronous control levels.

Top module: `svr_gated_recovery`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rx_clk is 0 and rx_data is 0.
- R2: While not locked, rx_data equals slicer_in as it was two clock edges earlier, and rx_clk stays 0.
- R3: The block locks when the last sixteen sampled bits, read oldest first, are 1110 0010 1110 0010 (0xE2E2 with the first-arrived bit as the MSB). Locked behaviour begins in the cycle after that sample.
- R4: While locked, rx_data is the most recently sampled bit. It changes only in the cycle where rx_clk rises and holds constant while rx_clk is high.
- R5: While locked, every sampled bit starts one rx_clk pulse. The pulse is high for exactly 8 oversample periods (8 × divisor clock cycles), and rx_clk never rises when no bit has been sampled.
- R6: An oversample tick occurs every divisor clock cycles. A detected change of the synchronized input restarts both the tick divider and the 0..15 phase count. A bit is sampled on the 8th tick after the last change and then every 16 ticks, and no bit is sampled in a cycle that detects a change.
- R7: With recov_en low, lock and search state are cleared at the next edge, so rx_clk is 0 from the following cycle and rx_data reverts to pass-through. A recov_en low sampled in the same cycle as the final start-word bit prevents the lock.
- R8: After recov_en returns high, a lock requires a complete start word received after that point. Bits sampled earlier do not count.
- R9: rate_hi = 1 selects divisor DIV_SLOW and rate_hi = 0 selects DIV_FAST. rate_hi may change only while recov_en is low.
- R10: Any other 16-bit sequence, for example 0xE2E3, leaves the block unlocked, with rx_clk 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slicer_in | input | 1 | Raw sliced receive level, asynchronous |
| rate_hi | input | 1 | 1 selects the slow bit rate, 0 the fast one |
| recov_en | input | 1 | Enables start-word search and recovery; low clears lock |
| rx_data | output | 1 | Pass-through level before lock, recovered bit after |
| rx_clk | output | 1 | Recovered-clock pulse per bit while locked, else 0 |

## Verification
Two pairs of functions can land in the same clock cycle. The first pair is an input transition detected on the very tick that would take the mid-bit sample. The stimulus lengthens and shortens bits alternately, so transitions fall on many tick phases, and a behavioural model compared every cycle judges whether the sample was correctly suppressed and the timing restarted. The second pair is recov_en falling on the exact edge that completes the start word. The stimulus predicts that edge from the model and drops the enable there, and the run is judged by the absence of any rx_clk rise afterwards.

// File: rtl/svr_pkg.sv
package svr_pkg;
  localparam int VEC_W = 16;
  localparam logic [VEC_W-1:0] START_VEC = 16'hE2E2;
  localparam int OVS = 16;            // oversamples per bit
  localparam int MID = OVS / 2 - 1;   // phase value of the mid-bit tick
  localparam int HALF = OVS / 2;      // ticks of recovered-clock high time

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } lock_t;
endpackage

// File: rtl/svr_sync.sv
module svr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync,
  output logic d_prev
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], d_async};
  end

  assign d_sync = sh_q[STAGES-1];
  assign d_prev = sh_q[STAGES];
endmodule

// File: rtl/svr_tick_gen.sv
module svr_tick_gen #(
  parameter int DIV_SLOW = 1302,
  parameter int DIV_FAST = 326,
  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST,
  localparam int CW      = $clog2(DIV_MAX + 1),
  localparam int LW      = $clog2(svr_pkg::HALF * DIV_MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rate_hi,
  input  logic          realign,
  output logic          tick,
  output logic [LW-1:0] pulse_len
);
  localparam logic [CW-1:0] SLOW_M1 = CW'(DIV_SLOW - 1);
  localparam logic [CW-1:0] FAST_M1 = CW'(DIV_FAST - 1);
  localparam logic [LW-1:0] LEN_SLOW_M1 = LW'(svr_pkg::HALF * DIV_SLOW - 1);
  localparam logic [LW-1:0] LEN_FAST_M1 = LW'(svr_pkg::HALF * DIV_FAST - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] div_m1;

  assign div_m1    = rate_hi ? SLOW_M1 : FAST_M1;
  assign tick      = (cnt_q >= div_m1);
  assign pulse_len = rate_hi ? LEN_SLOW_M1 : LEN_FAST_M1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (realign || tick) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/svr_bit_timer.sv
module svr_bit_timer
  import svr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic trans,
  input  logic din_s,
  output logic strobe,
  output logic bit_val
);
  localparam int PW = $clog2(OVS);

  logic [PW-1:0] phase_q;

  assign strobe  = tick && !trans && (phase_q == PW'(MID));
  assign bit_val = din_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase_q <= '0;
    else if (trans) phase_q <= '0;
    else if (tick)  phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/svr_vec_lock.sv
module svr_vec_lock
  import svr_pkg::*;
#(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          strobe,
  input  logic          bit_val,
  input  logic [LW-1:0] pulse_len,
  output logic          locked,
  output logic          rec_bit,
  output logic          pulse
);
  lock_t            st_q;
  logic [VEC_W-1:0] sr_q;
  logic [VEC_W-1:0] sr_nxt;
  logic [LW-1:0]    pc_q;

  assign sr_nxt = {sr_q[VEC_W-2:0], bit_val};
  assign locked = (st_q == ST_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_HUNT;
      sr_q    <= '0;
      rec_bit <= 1'b0;
      pulse   <= 1'b0;
      pc_q    <= '0;
    end else if (!en) begin
      st_q    <= ST_HUNT;
      sr_q    <= '0;
      rec_bit <= 1'b0;
      pulse   <= 1'b0;
      pc_q    <= '0;
    end else if (strobe) begin
      sr_q    <= sr_nxt;
      rec_bit <= bit_val;
      if (st_q == ST_HUNT && sr_nxt == START_VEC) st_q <= ST_LOCK;
      if (st_q == ST_LOCK) begin
        pulse <= 1'b1;
        pc_q  <= pulse_len;
      end
    end else if (pulse) begin
      if (pc_q == '0) pulse <= 1'b0;
      else            pc_q  <= pc_q - 1'b1;
    end
  end
endmodule

// File: rtl/svr_gated_recovery.sv
module svr_gated_recovery #(
  parameter int DIV_SLOW    = 1302,
  parameter int DIV_FAST    = 326,
  parameter int SYNC_STAGES = 2,
  localparam int DIV_MAX    = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST,
  localparam int LW         = $clog2(svr_pkg::HALF * DIV_MAX)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slicer_in,
  input  logic rate_hi,
  input  logic recov_en,
  output logic rx_data,
  output logic rx_clk
);
  logic          din_s, din_d, trans_w;
  logic          tick_w, strobe_w, bit_w;
  logic          locked_w, rec_bit_w, pulse_w;
  logic [LW-1:0] pulse_len_w;

  svr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(slicer_in),
    .d_sync(din_s), .d_prev(din_d)
  );

  assign trans_w = din_s ^ din_d;

  svr_tick_gen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tick (
    .clk(clk), .rst_n(rst_n), .rate_hi(rate_hi), .realign(trans_w),
    .tick(tick_w), .pulse_len(pulse_len_w)
  );

  svr_bit_timer u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .trans(trans_w),
    .din_s(din_s), .strobe(strobe_w), .bit_val(bit_w)
  );

  svr_vec_lock #(.LW(LW)) u_lock (
    .clk(clk), .rst_n(rst_n), .en(recov_en), .strobe(strobe_w),
    .bit_val(bit_w), .pulse_len(pulse_len_w),
    .locked(locked_w), .rec_bit(rec_bit_w), .pulse(pulse_w)
  );

  assign rx_data = locked_w ? rec_bit_w : din_s;
  assign rx_clk  = pulse_w;
endmodule

// File: rtl/svr_chk.sv
module svr_chk (
  input logic clk,
  input logic rst_n,
  input logic slicer_in,
  input logic recov_en,
  input logic rx_clk,
  input logic rx_data,
  input logic locked,
  input logic strobe
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && !locked) |-> (rx_data == $past(slicer_in, 2) && !rx_clk));

  // R3
  lock_at_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd1 && $rose(locked)) |-> $past(strobe));

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd1 && rx_clk && $past(rx_clk)) |-> $stable(rx_data));

  // R5
  rise_at_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd1 && $rose(rx_clk)) |-> ($past(strobe) && locked));

  // R7
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !recov_en |=> (!rx_clk && !locked));
endmodule

bind svr_gated_recovery svr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slicer_in(slicer_in), .recov_en(recov_en),
  .rx_clk(rx_clk), .rx_data(rx_data), .locked(locked_w), .strobe(strobe_w)
);

// File: tb/tb_svr_gated_recovery.sv
module tb_svr_gated_recovery;
  localparam int DS = 6;
  localparam int DF = 3;
  localparam logic [15:0] VEC = 16'hE2E2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slicer_in = 1'b0;
  logic rate_hi = 1'b1;
  logic recov_en = 1'b0;
  logic rx_data, rx_clk;

  always #5 clk = ~clk;

  svr_gated_recovery #(.DIV_SLOW(DS), .DIV_FAST(DF)) dut (
    .clk(clk), .rst_n(rst_n), .slicer_in(slicer_in), .rate_hi(rate_hi),
    .recov_en(recov_en), .rx_data(rx_data), .rx_clk(rx_clk)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // behavioural reference model, updated on every rising edge
  logic        m_s1 = 0, m_s2 = 0, m_s3 = 0;
  int          m_cnt = 0, m_phase = 0, m_pc = 0;
  logic [15:0] m_sr = '0;
  logic        m_locked = 0, m_bit = 0, m_pulse = 0;

  always @(posedge clk) begin : model
    int dv;
    bit tr, tk, sb;
    logic [15:0] nsr;
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_s3 <= 0; m_cnt <= 0; m_phase <= 0;
      m_sr <= '0; m_locked <= 0; m_bit <= 0; m_pulse <= 0; m_pc <= 0;
    end else begin
      dv  = rate_hi ? DS : DF;
      tr  = (m_s2 != m_s3);
      tk  = (m_cnt >= dv - 1);
      sb  = tk && !tr && (m_phase == 7);
      nsr = {m_sr[14:0], m_s2};
      m_s1 <= slicer_in; m_s2 <= m_s1; m_s3 <= m_s2;
      m_cnt <= (tr || tk) ? 0 : m_cnt + 1;
      m_phase <= tr ? 0 : (tk ? (m_phase + 1) % 16 : m_phase);
      if (!recov_en) begin
        m_sr <= '0; m_locked <= 0; m_bit <= 0; m_pulse <= 0; m_pc <= 0;
      end else if (sb) begin
        m_sr <= nsr; m_bit <= m_s2;
        if (!m_locked && nsr == VEC) m_locked <= 1;
        if (m_locked) begin m_pulse <= 1; m_pc <= 8 * dv - 1; end
      end else if (m_pulse) begin
        if (m_pc == 0) m_pulse <= 0; else m_pc <= m_pc - 1;
      end
    end
  end

  // every-cycle comparison and pulse bookkeeping, away from the active edge
  int   rises = 0, width = 0, last_w = 0;
  logic prev_c = 0, cur_d = 0;
  logic got[$];

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rx_data === (m_locked ? m_bit : m_s2), m_locked ? "R4" : "R2",
          "rx_data vs model", int'(rx_data), int'(m_locked ? m_bit : m_s2));
      chk(rx_clk === (m_locked && m_pulse), m_locked ? "R5" : "R2",
          "rx_clk vs model", int'(rx_clk), int'(m_locked && m_pulse));
    end
    if (rx_clk && !prev_c) begin rises++; width = 1; end
    else if (rx_clk)       width++;
    if (rx_clk) cur_d = rx_data;
    if (!rx_clk && prev_c) begin last_w = width; got.push_back(cur_d); end
    prev_c = rx_clk;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual %0d expected %0d", cyc, 150000);
      report();
    end
  end

  bit arm_drop = 0;
  bit dropped = 0;
  int jit_k = 0;

  function automatic bit match_next();
    int dv = rate_hi ? DS : DF;
    return (m_cnt >= dv - 1) && (m_s2 == m_s3) && (m_phase == 7) && !m_locked &&
           ({m_sr[14:0], m_s2} == VEC) && recov_en;
  endfunction

  task automatic hold(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      slicer_in = v;
      if (arm_drop && match_next()) begin
        recov_en = 1'b0; arm_drop = 0; dropped = 1;
      end
    end
  endtask

  task automatic send_bits(input logic [31:0] pat, input int nb, input int per);
    for (int i = nb - 1; i >= 0; i--) begin
      int len;
      len = per + ((jit_k % 2) ? per / 6 : -(per / 6));
      jit_k++;
      hold(pat[i], len);
    end
  endtask

  task automatic check_bits(input logic [31:0] pat, input int nb, input string req);
    chk(got.size() >= nb, req, "recovered bit count", got.size(), nb);
    for (int i = 0; i < nb && i < got.size(); i++)
      chk(got[i] == pat[nb-1-i], req, "recovered bit value", int'(got[i]), int'(pat[nb-1-i]));
  endtask

  initial begin
    int ps, pf;
    ps = 16 * DS;
    pf = 16 * DF;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rx_clk == 1'b0, "R1", "rx_clk in reset", int'(rx_clk), 0);
    chk(rx_data == 1'b0, "R1", "rx_data in reset", int'(rx_data), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(rx_clk == 1'b0, "R1", "rx_clk after reset", int'(rx_clk), 0);
    chk(rx_data == 1'b0, "R1", "rx_data after reset", int'(rx_data), 0);
    recov_en = 1'b1;

    // R3 R4 R6: slow rate, jittered bits, lock then recover
    rises = 0; got.delete();
    send_bits(32'h55, 8, ps);
    chk(rises == 0, "R2", "rx_clk rises before start word", rises, 0);
    send_bits(32'(VEC), 16, ps);
    send_bits(32'hB36, 12, ps);
    hold(1'b0, 3 * ps);
    check_bits(32'hB36, 12, "R3");
    chk(last_w == 8 * DS, "R5", "pulse width slow", last_w, 8 * DS);

    // R7: disable clears lock, pass-through returns
    @(negedge clk); recov_en = 1'b0;
    rises = 0;
    hold(1'b0, 6);
    chk(rx_clk == 1'b0, "R7", "rx_clk after disable", int'(rx_clk), 0);
    chk(rx_data == 1'b0, "R7", "pass-through low", int'(rx_data), 0);
    hold(1'b1, 4);
    chk(rx_data == 1'b1, "R7", "pass-through high", int'(rx_data), 1);
    chk(rises == 0, "R7", "rx_clk rises while disabled", rises, 0);

    // R8: re-armed, no start word, no clock
    recov_en = 1'b1;
    rises = 0;
    send_bits(32'hA5A5A, 20, ps);
    chk(rises == 0, "R8", "rx_clk rises without new start word", rises, 0);

    // R10: near-miss start word
    send_bits(32'h55, 8, ps);
    send_bits(32'hE2E3, 16, ps);
    send_bits(32'hF, 4, ps);
    hold(1'b1, 2 * ps);
    chk(rises == 0, "R10", "rx_clk rises after 0xE2E3", rises, 0);

    // R7: disable on the exact edge that completes the start word
    @(negedge clk); recov_en = 1'b0;
    hold(1'b0, 3);
    recov_en = 1'b1;
    rises = 0; dropped = 0; arm_drop = 1;
    send_bits(32'h55, 8, ps);
    send_bits(32'(VEC), 16, ps);
    send_bits(32'hB36, 12, ps);
    hold(1'b0, 2 * ps);
    arm_drop = 0;
    chk(dropped == 1, "R7", "enable dropped on completing sample", int'(dropped), 1);
    chk(rises == 0, "R7", "rx_clk rises after colliding disable", rises, 0);

    // R9: fast rate
    @(negedge clk); recov_en = 1'b0; rate_hi = 1'b0;
    hold(1'b0, 3);
    recov_en = 1'b1;
    rises = 0; got.delete();
    send_bits(32'h55, 8, pf);
    send_bits(32'(VEC), 16, pf);
    send_bits(32'h5C9, 12, pf);
    hold(1'b1, 3 * pf);
    check_bits(32'h5C9, 12, "R9");
    chk(last_w == 8 * DF, "R9", "pulse width fast", last_w, 8 * DF);

    report();
  end
endmodule